// File: doc/BRIEF.md
# Masked Indexed Store Unit

This block carries out the memory side of a family of unofficial indexed store operations on an 8-bit processor core. The byte that is stored is not a plain register value. It is the chosen source, which is A AND X, X alone or Y alone, ANDed with a page byte taken from the target address. The same masked byte is also put on the high half of the address bus during the write, so the store can land on a page other than the one the program intended. The page byte used for masking is the base high byte if the index did not carry into the high byte. If it did carry, the page byte is the base high byte plus one.

Each operation takes two bus cycles. The first is a dummy read at the address before fixup, issued whether or not a page was crossed. The second is the masked write. The stack-transfer variant also loads the stack pointer with A AND X during the dummy read cycle, and then stores in the same way as the A AND X variant. Effective-address arithmetic is done elsewhere. This unit only receives the base high byte, the low byte after indexing, and the carry flag that marks a page cross. No processor flags are touched.

Top module: `masked_store_unit`

## Requirements
- R1: After reset the unit is idle: `busy`, `mem_re`, `mem_we` and `s_we` are all 0.
- R2: One cycle after `start` is accepted, the unit does a dummy read. `mem_re`=1, `mem_we`=0, and `mem_addr` = {`base_hi`, `idx_lo`}. This happens for both values of `page_cross`.
- R3: Two cycles after `start`, the unit does exactly one write cycle with `mem_we`=1 and `mem_re`=0. In the following cycle it is idle again.
- R4: When `page_cross`=0, `mem_wdata` = source AND `base_hi`.
- R5: When `page_cross`=1, `mem_wdata` = source AND (`base_hi`+1 modulo 256). With `base_hi`=8'hFF this page byte is 8'h00.
- R6: During the write cycle, `mem_addr[15:8]` equals the masked byte written and `mem_addr[7:0]` equals `idx_lo`.
- R7: The `variant` encoding selects the source. 2'b00 stores A AND X, 2'b01 stores X, 2'b10 stores Y, and 2'b11 is the stack-transfer form, which stores A AND X.
- R8: For `variant`=2'b11 only, `s_we` is 1 for exactly the dummy read cycle, with `s_wdata` = A AND X. For the other variants `s_we` stays 0.
- R9: All operands are captured when `start` is accepted. A `start` pulse or an operand change while `busy`=1 has no effect on the operation in progress and does not start another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only while idle) |
| variant | input | 2 | Source select, encoded as listed in R7 |
| reg_a | input | 8 | Accumulator value |
| reg_x | input | 8 | X index register value |
| reg_y | input | 8 | Y index register value |
| base_hi | input | 8 | High byte of the base address before fixup |
| idx_lo | input | 8 | Low byte of the indexed address |
| page_cross | input | 1 | The index carried into the high byte |
| busy | output | 1 | An operation is in progress |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Dummy read strobe |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| s_we | output | 1 | Stack pointer load strobe |
| s_wdata | output | 8 | New stack pointer value |

## Verification
`start` is registered into a two-state sequence. The dummy read and the stack pointer load are therefore visible in the first cycle after the accepting clock edge. The masked write is visible in the second cycle, and the unit is idle in the third. The bench drives inputs and samples outputs only on falling edges, so each check reads one of these three cycles with no race against the rising edge. A sweep over all variants, both carry states and several base pages, including 8'hFF where the page byte wraps, compares every cycle against values the bench computes from the requirements. During the read cycle the bench also pulses `start` again and scrambles the operands, to check that the captured values are the ones used.

// File: rtl/msu_pkg.sv
package msu_pkg;

  typedef enum logic [1:0] {
    VAR_AND_AX = 2'b00,
    VAR_X_ONLY = 2'b01,
    VAR_Y_ONLY = 2'b10,
    VAR_STACK  = 2'b11
  } msu_variant_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } msu_phase_e;

endpackage

// File: rtl/msu_source_sel.sv
module msu_source_sel
  import msu_pkg::*;
#(
  parameter int DW = 8
) (
  input  msu_variant_e  variant,
  input  logic [DW-1:0] a_val,
  input  logic [DW-1:0] x_val,
  input  logic [DW-1:0] y_val,
  output logic [DW-1:0] src,
  output logic [DW-1:0] ax_and
);

  function automatic logic [DW-1:0] pick_source(msu_variant_e v,
                                                 logic [DW-1:0] a,
                                                 logic [DW-1:0] x,
                                                 logic [DW-1:0] y);
    case (v)
      VAR_X_ONLY: return x;
      VAR_Y_ONLY: return y;
      default:    return a & x;
    endcase
  endfunction

  assign ax_and = a_val & x_val;
  assign src    = pick_source(variant, a_val, x_val, y_val);

endmodule

// File: rtl/msu_sequencer.sv
module msu_sequencer
  import msu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic rd_cyc,
  output logic wr_cyc,
  output logic busy
);

  msu_phase_e phase_q, phase_d;

  assign accept = start && (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:  if (start) phase_d = PH_READ;
      PH_READ:  phase_d = PH_WRITE;
      PH_WRITE: phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign rd_cyc = (phase_q == PH_READ);
  assign wr_cyc = (phase_q == PH_WRITE);
  assign busy   = rd_cyc || wr_cyc;

endmodule

// File: rtl/msu_addr_gen.sv
module msu_addr_gen #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic [DW-1:0] base_hi,
  input  logic [DW-1:0] idx_lo,
  input  logic          crossed,
  input  logic [DW-1:0] src,
  output logic [DW-1:0] page_byte,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  // Page byte used for masking: the fixed page on a carry, else the base page.
  function automatic logic [DW-1:0] page_of(logic [DW-1:0] hi, logic c);
    return c ? hi + {{(DW-1){1'b0}}, 1'b1} : hi;
  endfunction

  function automatic logic [DW-1:0] masked(logic [DW-1:0] s, logic [DW-1:0] p);
    return s & p;
  endfunction

  assign page_byte = page_of(base_hi, crossed);
  assign wr_data   = masked(src, page_byte);
  assign rd_addr   = {base_hi, idx_lo};
  assign wr_addr   = {wr_data, idx_lo};

endmodule

// File: rtl/masked_store_unit.sv
module masked_store_unit
  import msu_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    variant,
  input  logic [DW-1:0] reg_a,
  input  logic [DW-1:0] reg_x,
  input  logic [DW-1:0] reg_y,
  input  logic [DW-1:0] base_hi,
  input  logic [DW-1:0] idx_lo,
  input  logic          page_cross,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          s_we,
  output logic [DW-1:0] s_wdata
);

  logic          accept, rd_cyc, wr_cyc;
  msu_variant_e  var_q;
  logic [DW-1:0] a_q, x_q, y_q, base_q, lo_q;
  logic          cross_q;
  logic [DW-1:0] src, ax_and, page_byte, wr_data;
  logic [AW-1:0] rd_addr, wr_addr;

  msu_sequencer u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept),
    .rd_cyc (rd_cyc),
    .wr_cyc (wr_cyc),
    .busy   (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      var_q   <= VAR_AND_AX;
      a_q     <= '0;
      x_q     <= '0;
      y_q     <= '0;
      base_q  <= '0;
      lo_q    <= '0;
      cross_q <= 1'b0;
    end else if (accept) begin
      var_q   <= msu_variant_e'(variant);
      a_q     <= reg_a;
      x_q     <= reg_x;
      y_q     <= reg_y;
      base_q  <= base_hi;
      lo_q    <= idx_lo;
      cross_q <= page_cross;
    end
  end

  msu_source_sel #(.DW(DW)) u_src (
    .variant (var_q),
    .a_val   (a_q),
    .x_val   (x_q),
    .y_val   (y_q),
    .src     (src),
    .ax_and  (ax_and)
  );

  msu_addr_gen #(.DW(DW)) u_addr (
    .base_hi   (base_q),
    .idx_lo    (lo_q),
    .crossed   (cross_q),
    .src       (src),
    .page_byte (page_byte),
    .rd_addr   (rd_addr),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  assign mem_re    = rd_cyc;
  assign mem_we    = wr_cyc;
  assign mem_addr  = wr_cyc ? wr_addr : (rd_cyc ? rd_addr : '0);
  assign mem_wdata = wr_cyc ? wr_data : '0;
  assign s_we      = rd_cyc && (var_q == VAR_STACK);
  assign s_wdata   = s_we ? ax_and : '0;

endmodule

// File: rtl/msu_checks.sv
module msu_checks #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic [AW-1:0] mem_addr,
  input logic          mem_re,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic          s_we,
  input logic [DW-1:0] page_byte,
  input logic [DW-1:0] src
);

  a_r2_start_gives_read: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> mem_re);

  a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (mem_we && !mem_re));

  a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_re));

  a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  a_r6_high_byte_is_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[AW-1:DW] == mem_wdata));

  a_r5_data_within_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_wdata & ~page_byte) == '0 && (mem_wdata & ~src) == '0));

  a_r8_stack_load_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    s_we |-> mem_re);

  a_r9_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> busy);

endmodule

bind masked_store_unit msu_checks #(.DW(DW)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .mem_addr  (mem_addr),
  .mem_re    (mem_re),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .s_we      (s_we),
  .page_byte (page_byte),
  .src       (src)
);

// File: tb/tb_masked_store_unit.sv
module tb_masked_store_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  variant = 2'b00;
  logic [7:0]  reg_a = '0, reg_x = '0, reg_y = '0, base_hi = '0, idx_lo = '0;
  logic        page_cross = 1'b0;
  logic        busy, mem_re, mem_we, s_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, s_wdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] lfsr = 8'h5D;

  always #10 clk = ~clk;

  masked_store_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .variant(variant),
    .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y), .base_hi(base_hi),
    .idx_lo(idx_lo), .page_cross(page_cross), .busy(busy),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .s_we(s_we), .s_wdata(s_wdata)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] next_rand();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    return lfsr;
  endfunction

  // Bench model: source by R7, page by R4/R5 computed as an integer sum.
  function automatic int model_data(int v, int a, int x, int y, int b, int c);
    int s;
    int p;
    if (v == 1)      s = x;
    else if (v == 2) s = y;
    else             s = a & x;
    p = (b + c) % 256;
    return s & p;
  endfunction

  task automatic run_op(input int v, input int a, input int x, input int y,
                        input int b, input int lo, input int c, input bit disturb);
    int exp_d;
    exp_d = model_data(v, a, x, y, b, c);
    @(negedge clk);
    variant = 2'(v); reg_a = 8'(a); reg_x = 8'(x); reg_y = 8'(y);
    base_hi = 8'(b); idx_lo = 8'(lo); page_cross = c[0];
    start = 1'b1;
    @(negedge clk);
    start = disturb;
    // dummy read cycle
    check("R2 read strobe", int'(mem_re), 1);
    check("R2 no write in read", int'(mem_we), 0);
    check("R2 read address", int'(mem_addr), (b << 8) | lo);
    check("R8 stack strobe", int'(s_we), (v == 3) ? 1 : 0);
    if (v == 3) check("R8 stack value", int'(s_wdata), a & x);
    if (disturb) begin
      reg_a = ~reg_a; reg_x = ~reg_x; reg_y = ~reg_y;
      base_hi = ~base_hi; idx_lo = ~idx_lo; page_cross = ~page_cross;
      variant = ~variant;
    end
    @(negedge clk);
    start = 1'b0;
    check("R3 write strobe", int'(mem_we), 1);
    check("R3 no read in write", int'(mem_re), 0);
    check(c ? "R5 crossed data" : "R4 plain data", int'(mem_wdata), exp_d);
    check("R7/R6 write address", int'(mem_addr), (exp_d << 8) | lo);
    check("R8 no stack load in write", int'(s_we), 0);
    @(negedge clk);
    check(disturb ? "R9 start ignored while busy" : "R3 idle after write",
          int'(busy), 0);
    check("R3 no write after op", int'(mem_we), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int bases[6];
    bases[0] = 8'h00; bases[1] = 8'h7F; bases[2] = 8'hFF;
    bases[3] = 8'hA5; bases[4] = 8'h3C; bases[5] = 8'hFE;
    repeat (2) @(negedge clk);
    check("R1 busy at reset", int'(busy), 0);
    check("R1 re at reset", int'(mem_re), 0);
    check("R1 we at reset", int'(mem_we), 0);
    check("R1 s_we at reset", int'(s_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", int'(busy), 0);

    for (int v = 0; v < 4; v++)
      for (int c = 0; c < 2; c++)
        for (int bi = 0; bi < 6; bi++) begin
          int a, x, y, lo;
          a = next_rand(); x = next_rand(); y = next_rand(); lo = next_rand();
          run_op(v, a, x, y, bases[bi], lo, c, 1'b0);
        end

    // All-ones sources show the page byte directly, including the wrap.
    for (int v = 0; v < 4; v++) begin
      run_op(v, 255, 255, 255, 8'hFF, 8'h10, 1, 1'b0);
      run_op(v, 255, 255, 255, 8'h12, 8'h34, 1, 1'b0);
      run_op(v, 255, 255, 255, 8'h12, 8'h34, 0, 1'b0);
    end

    // R9: restart and operand changes during the operation are ignored.
    for (int v = 0; v < 4; v++)
      run_op(v, 8'hC3, 8'h5A, 8'h96, 8'h6E, 8'hF0, v % 2, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule